// File: doc/BRIEF.md
# Saturating Power-of-Two Clock Prescaler

This block turns a fast master clock into a slower timing reference without gating the clock itself. A 4-bit code selects an exponent x, and the block then produces one enable pulse every 2^x master-clock cycles. Logic elsewhere in the same clock domain qualifies its registers with that pulse. A square wave at the same divided rate is also produced so the chosen rate can be watched on a pin or a logic analyser.

Only exponents 0 to 8 exist, giving ratios 1 to 256. Codes 9 to 15 saturate to exponent 8 and do not wrap. The period counter restarts from zero at the end of every period. A new code is adopted only at that boundary. Changing the code therefore never produces a shortened or stretched fragment of a period. A synchronous reset restarts the period and adopts whatever code is present at the reset edge.

Top module: `pow2_tick_gen`

## Requirements
- R1: For a code x in 0..8 held steady, `tick_o` is high for exactly one cycle in every 2^x consecutive cycles, and successive pulses are exactly 2^x cycles apart.
- R2: The code is read as an unsigned value on bits [3:0] of `code_i`. Any value from 9 to 15 gives exactly the same outputs as value 8, which is a period of 256 cycles.
- R3: With exponent 0, `tick_o` is high in every cycle and `div_o` is held high.
- R4: With exponent x of 1 or more, `div_o` is low during the first 2^(x-1) cycles of each period and high during the remaining 2^(x-1) cycles. The first cycle of a period is the one in which `tick_o` is high.
- R5: The code is sampled only in the last cycle of a period, and the sampled value sets the length of the next period. Values that `code_i` takes in any other cycle have no effect on the outputs.
- R6: In the first cycle after a clock edge at which `rst_i` is high, `tick_o` is 1 and a new period begins. The exponent used for that period is the saturated code present at the reset edge, so `div_o` is 1 only if that exponent is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset; restarts the period |
| code_i | input | 4 | Prescaler code; the exponent is this value, limited to 8 |
| div_o | output | 1 | Registered square wave at the divided rate |
| tick_o | output | 1 | Registered single-cycle enable, one per period |

## Verification
The properties assume that `rst_i` is high at the first clock edge. They also assume that `code_i` is settled before each rising edge, because the block registers it without synchronisation. The stimulus holds reset for the opening edges. It drives `code_i` and `rst_i` only on falling edges, so every value the block samples is stable. Within those limits the stimulus changes the code freely, including every cycle in the middle of a period and during reset. This exercises the rule that only the value present at a period boundary counts.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

  // Default sizing shared by the prescaler modules.
  localparam int unsigned DEF_MAX_EXP = 8;
  localparam int unsigned DEF_CODE_W  = 4;

  // Bits needed to hold an exponent in the range 0..max_exp.
  function automatic int unsigned exp_bits(int unsigned max_exp);
    return (max_exp < 1) ? 1 : $clog2(max_exp + 1);
  endfunction

endpackage

// File: rtl/pscl_code_clamp.sv
module pscl_code_clamp #(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned MAX_EXP = 8,
  parameter int unsigned EXP_W   = 4
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [EXP_W-1:0]  exp_o
);

  localparam int unsigned LIMIT = MAX_EXP;

  // Saturate: anything beyond the largest exponent pins to it.
  always_comb begin
    if (int'(code_i) > LIMIT) exp_o = EXP_W'(LIMIT);
    else                      exp_o = EXP_W'(code_i);
  end

endmodule

// File: rtl/pscl_period_counter.sv
module pscl_period_counter #(
  parameter int unsigned MAX_EXP = 8,
  parameter int unsigned EXP_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [EXP_W-1:0]   new_exp_i,
  output logic [MAX_EXP-1:0] cnt_q,
  output logic [EXP_W-1:0]   act_q,
  output logic [MAX_EXP-1:0] cnt_nxt,
  output logic [EXP_W-1:0]   act_nxt
);

  logic [MAX_EXP-1:0] lane_done;
  logic               last_cycle;

  // A counter bit at or above the active exponent is always zero, so it
  // does not count towards the end of the period. A bit below it must be one.
  for (genvar i = 0; i < MAX_EXP; i++) begin : g_lane
    assign lane_done[i] = cnt_q[i] | (int'(act_q) <= i);
  end

  assign last_cycle = &lane_done;

  // Next-state values are exported so the output stage can register
  // them in the same edge as the counter itself.
  always_comb begin
    if (rst_i || last_cycle) begin
      cnt_nxt = '0;
      act_nxt = new_exp_i;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
      act_nxt = act_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      act_q <= new_exp_i;
    end else begin
      cnt_q <= cnt_nxt;
      act_q <= act_nxt;
    end
  end

endmodule

// File: rtl/pscl_out_stage.sv
module pscl_out_stage #(
  parameter int unsigned MAX_EXP = 8,
  parameter int unsigned EXP_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [MAX_EXP-1:0] cnt_nxt_i,
  input  logic [EXP_W-1:0]   act_nxt_i,
  output logic               tick_o,
  output logic               div_o
);

  logic [MAX_EXP-1:0] pick;
  logic               div_d;
  logic               tick_d;

  // For exponent i the square wave is counter bit i-1: low in the first
  // half of the period, high in the second.
  for (genvar i = 1; i <= MAX_EXP; i++) begin : g_pick
    assign pick[i-1] = (int'(act_nxt_i) == i) & cnt_nxt_i[i-1];
  end

  assign div_d  = (act_nxt_i == '0) | (|pick);
  assign tick_d = (cnt_nxt_i == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tick_o <= 1'b1;
      div_o  <= (act_nxt_i == '0);
    end else begin
      tick_o <= tick_d;
      div_o  <= div_d;
    end
  end

endmodule

// File: rtl/pow2_tick_gen.sv
module pow2_tick_gen
  import pscl_pkg::*;
#(
  parameter int unsigned MAX_EXP = DEF_MAX_EXP,
  parameter int unsigned CODE_W  = DEF_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_o,
  output logic              tick_o
);

  localparam int unsigned EXP_W = exp_bits(MAX_EXP);

  logic [EXP_W-1:0]   sat_exp;
  logic [MAX_EXP-1:0] cnt_q;
  logic [EXP_W-1:0]   act_q;
  logic [MAX_EXP-1:0] cnt_nxt;
  logic [EXP_W-1:0]   act_nxt;

  pscl_code_clamp #(
    .CODE_W (CODE_W),
    .MAX_EXP(MAX_EXP),
    .EXP_W  (EXP_W)
  ) u_clamp (
    .code_i(code_i),
    .exp_o (sat_exp)
  );

  pscl_period_counter #(
    .MAX_EXP(MAX_EXP),
    .EXP_W  (EXP_W)
  ) u_count (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .new_exp_i(sat_exp),
    .cnt_q    (cnt_q),
    .act_q    (act_q),
    .cnt_nxt  (cnt_nxt),
    .act_nxt  (act_nxt)
  );

  pscl_out_stage #(
    .MAX_EXP(MAX_EXP),
    .EXP_W  (EXP_W)
  ) u_out (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cnt_nxt_i(cnt_nxt),
    .act_nxt_i(act_nxt),
    .tick_o   (tick_o),
    .div_o    (div_o)
  );

endmodule

// File: rtl/pscl_checker.sv
module pscl_checker #(
  parameter int unsigned MAX_EXP = 8,
  parameter int unsigned EXP_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               div,
  input logic [MAX_EXP-1:0] cnt,
  input logic [EXP_W-1:0]   act
);

  assert_exp_saturated_R2: assert property (@(posedge clk) disable iff (rst)
    int'(act) <= MAX_EXP);

  assert_tick_marks_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    tick == (cnt == '0));

  assert_count_below_ratio_R1: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < (1 << int'(act)));

  assert_unit_ratio_R3: assert property (@(posedge clk) disable iff (rst)
    (act == '0) |-> (tick && div));

  assert_div_low_at_start_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && act != '0) |-> !div);

  assert_exp_held_mid_period_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |-> $stable(act));

  assert_reset_restart_R6: assert property (@(posedge clk)
    $past(rst) |-> (tick && cnt == '0));

endmodule

bind pow2_tick_gen pscl_checker #(
  .MAX_EXP(MAX_EXP),
  .EXP_W  (EXP_W)
) u_chk (
  .clk (clk_i),
  .rst (rst_i),
  .tick(tick_o),
  .div (div_o),
  .cnt (cnt_q),
  .act (act_q)
);

// File: tb/tb_pow2_tick_gen.sv
module tb_pow2_tick_gen;

  logic       clk    = 1'b0;
  logic       rst_i  = 1'b1;
  logic [3:0] code_i = 4'd0;
  logic       div_o;
  logic       tick_o;

  pow2_tick_gen dut (
    .clk_i (clk_i_w),
    .rst_i (rst_i),
    .code_i(code_i),
    .div_o (div_o),
    .tick_o(tick_o)
  );

  wire clk_i_w = clk;

  always #5 clk = ~clk;

  typedef struct {
    bit    en;
    bit    dv;
    string tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int        compared   = 0;
  int        mismatched = 0;
  int        mp         = 0;
  int        mex        = 0;
  string     cur_tag    = "R6";
  bit        finished   = 1'b0;

  function automatic int sat(int c);
    return (c > 8) ? 8 : c;
  endfunction

  function automatic bit exp_div(int p, int e);
    if (e == 0) return 1'b1;
    return p >= (1 << (e - 1));
  endfunction

  // Driver: apply inputs on the falling edge, advance the reference
  // model at the rising edge and queue the outputs it predicts.
  task automatic cyc(bit r, int c);
    @(negedge clk);
    rst_i  = r;
    code_i = 4'(c);
    @(posedge clk);
    if (r || mp == (1 << mex) - 1) begin
      mp  = 0;
      mex = sat(c);
    end else begin
      mp++;
    end
    #1;
    sb_q.push_back('{en: (mp == 0), dv: exp_div(mp, mex), tag: cur_tag});
  endtask

  // Monitor: compare queued predictions well after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        compared++;
        if (tick_o !== it.en || div_o !== it.dv) begin
          mismatched++;
          $display("FAIL %s: tick=%b div=%b expected tick=%b div=%b at %0t",
                   it.tag, tick_o, div_o, it.en, it.dv, $time);
        end
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      report();
    end
  end

  initial begin
    // R6: reset state with code 3
    cur_tag = "R6";
    cyc(1'b1, 3);
    cyc(1'b1, 3);
    // R1: steady ratio 8
    cur_tag = "R1";
    repeat (20) cyc(1'b0, 3);
    // R5: code toggles every cycle; only boundary samples count
    cur_tag = "R5";
    for (int k = 0; k < 40; k++) cyc(1'b0, (k % 2 == 1) ? 6 : 1);
    // R3: exponent zero
    cur_tag = "R3";
    repeat (80) cyc(1'b0, 0);
    // R4 and R1: each exponent 1..8 for over two periods
    cur_tag = "R4";
    for (int x = 1; x <= 8; x++) repeat ((2 << x) + 3) cyc(1'b0, x);
    // R2: saturating codes 9..15
    cur_tag = "R2";
    for (int c = 9; c <= 15; c++) repeat (270) cyc(1'b0, c);
    // R6: reset in mid-period, then with a saturating code and with zero
    cur_tag = "R6";
    repeat (37) cyc(1'b0, 7);
    cyc(1'b1, 12);
    cur_tag = "R2";
    repeat (300) cyc(1'b0, 12);
    cur_tag = "R6";
    repeat (3) cyc(1'b0, 5);
    cyc(1'b1, 0);
    cur_tag = "R3";
    repeat (6) cyc(1'b0, 0);
    @(posedge clk);
    #5;
    finished = 1'b1;
    report();
  end

endmodule